// File: doc/BRIEF.md
# Flash Reset and Deep Power-Down Sequencer

This block watches the active-low reset/power-down line of a flash array and decides, clock by clock, whether reads and writes may proceed. A low level on that line only counts once it has been sampled for a minimum number of consecutive cycles. Shorter glitches are ignored. A qualified low with no operation running sends the device straight into deep power-down. A qualified low while the external program/erase engine reports busy aborts that operation. The block pulses an abort flag so the affected location or block can be marked invalid, then waits through a fixed shutdown interval.

When the shutdown interval ends, the reset level chooses the next state. If the line is already high, the device wakes at once. If it is still low, the device stays in deep power-down. Every wake-up clears the command interface back to array reads, which is signalled by a one-cycle pulse carrying the status reset value 0x80. After a wake-up, separate down-counters hold off reads and writes. Because the wake-up begins at the end of shutdown, an abort measures both delays from that point, not from the moment the line was released.

Deselecting the chip only disables the outputs. It neither stops a running operation nor changes any grant.

Top module: `flash_rst_seq`

## Requirements
- R1: After system reset, rd_ok_o and wr_ok_o are 1, and abort_o, status_ld_o and status_o are 0.
- R2: With busy_i low, sampling rp_n_i low at PULSE_CYC consecutive clock edges drops rd_ok_o and wr_ok_o to 0 from that edge on. The block then stays in power-down (both 0, out_dis_o 1) for as long as rp_n_i stays low.
- R3: A low run on rp_n_i shorter than PULSE_CYC edges changes no output and never raises abort_o.
- R4: If busy_i is high at the qualifying edge, abort_o is 1 for exactly one cycle. rd_ok_o and wr_ok_o then stay 0 for SHUT_CYC cycles, whatever rp_n_i and busy_i do.
- R5: At the last shutdown edge, rp_n_i high starts wake-up, and rp_n_i low enters power-down. From power-down, rp_n_i sampled high starts wake-up.
- R6: Each start of wake-up gives status_ld_o = 1 for one cycle, with status_o = 0x80 in that cycle. status_o is 0x00 in every other cycle.
- R7: rd_ok_o becomes 1 RD_REC_CYC edges after the wake-up start edge.
- R8: wr_ok_o becomes 1 WR_REC_CYC edges after the wake-up start edge. After an abort, that start edge is the end of shutdown, not the release of rp_n_i.
- R9: out_dis_o is 1 exactly when ce_n_i is 1 or rd_ok_o is 0.
- R10: ce_n_i high while busy_i is high does not abort anything and does not change rd_ok_o or wr_ok_o.
- R11: rp_n_i sampled low during recovery returns the block to power-down at that edge, with no minimum-pulse check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low |
| rp_n_i | input | 1 | Device reset/power-down line, active low, synchronous to clk |
| busy_i | input | 1 | Program/erase engine is running |
| ce_n_i | input | 1 | Chip deselect, active high |
| rd_ok_o | output | 1 | Array reads allowed |
| wr_ok_o | output | 1 | Writes allowed |
| out_dis_o | output | 1 | Data outputs held in high impedance |
| abort_o | output | 1 | One-cycle pulse: running operation aborted, target data invalid |
| status_ld_o | output | 1 | One-cycle pulse: command interface reset to array reads |
| status_o | output | 8 | Status reset value, 0x80 during status_ld_o |

## Verification
A wrong state or counter shows up at the grant outputs. A miscounted pulse qualifier drops rd_ok_o one edge early or late. It can also let a short glitch through, which shows as a grant falling with no abort reason. A shutdown interval that ends one cycle off moves the status_ld_o pulse, and the whole recovery profile shifts with it within a few cycles. A wrong end-of-shutdown choice shows at once, as a wake-up pulse while rp_n_i is low or as no pulse after it is high. The scoreboard compares every output on every cycle, so any such slip is caught at the first edge where it appears.

// File: rtl/flash_rst_seq.sv
module flash_rst_seq #(
  parameter int PULSE_CYC   = 8,
  parameter int SHUT_CYC    = 16,
  parameter int RD_REC_CYC  = 6,
  parameter int WR_REC_CYC  = 10,
  parameter logic [7:0] STATUS_INIT = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rp_n_i,
  input  logic       busy_i,
  input  logic       ce_n_i,
  output logic       rd_ok_o,
  output logic       wr_ok_o,
  output logic       out_dis_o,
  output logic       abort_o,
  output logic       status_ld_o,
  output logic [7:0] status_o
);
  localparam int M1   = (PULSE_CYC > SHUT_CYC) ? PULSE_CYC : SHUT_CYC;
  localparam int M2   = (RD_REC_CYC > WR_REC_CYC) ? RD_REC_CYC : WR_REC_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_RUN, S_LOW, S_SHUT, S_PD, S_WAKE} st_e;

  st_e           st;
  logic [CW-1:0] cnt, rcnt, wcnt;
  logic          abort_q, ld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_RUN;
      cnt     <= '0;
      rcnt    <= '0;
      wcnt    <= '0;
      abort_q <= 1'b0;
      ld_q    <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      ld_q    <= 1'b0;
      case (st)
        S_RUN:
          if (!rp_n_i) begin
            st  <= S_LOW;
            cnt <= CW'(PULSE_CYC - 1);
          end
        S_LOW:
          if (rp_n_i) st <= S_RUN;
          else if (cnt == CW'(1)) begin
            if (busy_i) begin
              st      <= S_SHUT;
              cnt     <= CW'(SHUT_CYC);
              abort_q <= 1'b1;
            end else st <= S_PD;
          end else cnt <= cnt - 1'b1;
        S_SHUT:
          if (cnt == CW'(1)) begin
            if (rp_n_i) begin
              st   <= S_WAKE;
              rcnt <= CW'(RD_REC_CYC);
              wcnt <= CW'(WR_REC_CYC);
              ld_q <= 1'b1;
            end else st <= S_PD;
          end else cnt <= cnt - 1'b1;
        S_PD:
          if (rp_n_i) begin
            st   <= S_WAKE;
            rcnt <= CW'(RD_REC_CYC);
            wcnt <= CW'(WR_REC_CYC);
            ld_q <= 1'b1;
          end
        S_WAKE:
          if (!rp_n_i) st <= S_PD;
          else begin
            if (rcnt != '0) rcnt <= rcnt - 1'b1;
            if (wcnt != '0) wcnt <= wcnt - 1'b1;
            if (rcnt <= CW'(1) && wcnt <= CW'(1)) st <= S_RUN;
          end
        default: st <= S_RUN;
      endcase
    end
  end

  wire live = (st == S_RUN) || (st == S_LOW);
  assign rd_ok_o     = live || (st == S_WAKE && rcnt == '0);
  assign wr_ok_o     = live || (st == S_WAKE && wcnt == '0);
  assign out_dis_o   = ce_n_i | ~rd_ok_o;
  assign abort_o     = abort_q;
  assign status_ld_o = ld_q;
  assign status_o    = ld_q ? STATUS_INIT : 8'h00;

  assert_abort_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);
  assert_abort_needs_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $past(busy_i));
  assert_abort_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (!rd_ok_o && !wr_ok_o));
  assert_rd_drop_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_ok_o) |-> !$past(rp_n_i));
  assert_wr_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_ok_o) |-> $past(rp_n_i));
  assert_wake_blocks_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_ld_o |-> !wr_ok_o);
endmodule

// File: tb/tb_flash_rst_seq.sv
`timescale 1ns/1ps
module tb_flash_rst_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rp_n = 1'b1, busy = 1'b0, ce_n = 1'b0;
  logic rd_ok, wr_ok, out_dis, abort, st_ld;
  logic [7:0] st_val;

  typedef struct {
    logic rd, wr, dis, ab, ld;
    string req;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_rst_seq #(.PULSE_CYC(3), .SHUT_CYC(4), .RD_REC_CYC(3), .WR_REC_CYC(5)) dut (
    .clk(clk), .rst_n(rst_n), .rp_n_i(rp_n), .busy_i(busy), .ce_n_i(ce_n),
    .rd_ok_o(rd_ok), .wr_ok_o(wr_ok), .out_dis_o(out_dis), .abort_o(abort),
    .status_ld_o(st_ld), .status_o(st_val));

  always @(posedge clk) begin
    #1;
    if (q.size() != 0) begin
      exp_t e;
      logic [7:0] ev;
      e = q.pop_front();
      ev = e.ld ? 8'h80 : 8'h00;
      checks++;
      if ({rd_ok, wr_ok, out_dis, abort, st_ld} !== {e.rd, e.wr, e.dis, e.ab, e.ld} || st_val !== ev) begin
        fails++;
        $display("FAIL %s: rd/wr/dis/ab/ld/st got %b%b%b%b%b/%h exp %b%b%b%b%b/%h",
                 e.req, rd_ok, wr_ok, out_dis, abort, st_ld, st_val,
                 e.rd, e.wr, e.dis, e.ab, e.ld, ev);
      end
    end
  end

  task automatic cyc(input logic rp, input logic bz, input logic ce,
                     input logic erd, input logic ewr, input logic edis,
                     input logic eab, input logic eld, input string req);
    exp_t e;
    @(negedge clk);
    rp_n = rp; busy = bz; ce_n = ce;
    e.rd = erd; e.wr = ewr; e.dis = edis; e.ab = eab; e.ld = eld; e.req = req;
    q.push_back(e);
  endtask

  task automatic wake_tail(input string req);
    cyc(1, 0, 0, 0, 0, 1, 0, 0, req);
    cyc(1, 0, 0, 0, 0, 1, 0, 0, req);
    cyc(1, 0, 0, 1, 0, 0, 0, 0, {req, " R7 rd ready"});
    cyc(1, 0, 0, 1, 0, 0, 0, 0, req);
    cyc(1, 0, 0, 1, 1, 0, 0, 0, {req, " R8 wr ready"});
    cyc(1, 0, 0, 1, 1, 0, 0, 0, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(1, 0, 0, 1, 1, 0, 0, 0, "R1 reset state");

    // R3: two-cycle glitch, busy high too
    cyc(0, 1, 0, 1, 1, 0, 0, 0, "R3 glitch");
    cyc(0, 1, 0, 1, 1, 0, 0, 0, "R3 glitch");
    cyc(1, 1, 0, 1, 1, 0, 0, 0, "R3 glitch end");
    cyc(1, 0, 0, 1, 1, 0, 0, 0, "R3 after");

    // R2: idle power-down, then R5/R6 wake from power-down
    cyc(0, 0, 0, 1, 1, 0, 0, 0, "R2 qualify");
    cyc(0, 0, 0, 1, 1, 0, 0, 0, "R2 qualify");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R2 power-down");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R2 hold");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R2 hold");
    cyc(1, 0, 0, 0, 0, 1, 0, 1, "R5 R6 wake from pd");
    wake_tail("R7 R8 pd recovery");

    // R4/R5/R8: abort, rp released early, delays from end of shutdown
    cyc(0, 1, 0, 1, 1, 0, 0, 0, "R4 qualify");
    cyc(0, 1, 0, 1, 1, 0, 0, 0, "R4 qualify");
    cyc(0, 1, 0, 0, 0, 1, 1, 0, "R4 abort pulse");
    cyc(1, 0, 0, 0, 0, 1, 0, 0, "R4 shutdown");
    cyc(1, 0, 0, 0, 0, 1, 0, 0, "R4 shutdown");
    cyc(1, 0, 0, 0, 0, 1, 0, 0, "R4 shutdown");
    cyc(1, 0, 0, 0, 0, 1, 0, 1, "R5 R6 wake at shutdown end");
    wake_tail("R8 abort recovery");

    // R5: rp still low at end of shutdown -> power-down
    cyc(0, 1, 0, 1, 1, 0, 0, 0, "R5 qualify");
    cyc(0, 1, 0, 1, 1, 0, 0, 0, "R5 qualify");
    cyc(0, 1, 0, 0, 0, 1, 1, 0, "R5 abort");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R5 shutdown");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R5 shutdown");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R5 shutdown");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R5 into pd no wake");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R5 pd hold");
    cyc(1, 0, 0, 0, 0, 1, 0, 1, "R6 wake");

    // R11: rp low during recovery
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R11 back to pd");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R11 pd hold");
    cyc(1, 0, 0, 0, 0, 1, 0, 1, "R11 R6 wake again");
    wake_tail("R7 R8 second recovery");

    // R9/R10: deselect while busy
    cyc(1, 1, 1, 1, 1, 1, 0, 0, "R9 R10 deselect busy");
    cyc(1, 1, 1, 1, 1, 1, 0, 0, "R10 deselect busy");
    cyc(1, 1, 1, 1, 1, 1, 0, 0, "R10 deselect busy");
    cyc(1, 1, 0, 1, 1, 0, 0, 0, "R9 reselect");
    cyc(1, 0, 0, 1, 1, 0, 0, 0, "R10 done");

    // R9: deselected during power-down still disabled
    cyc(0, 0, 1, 1, 1, 1, 0, 0, "R9 qualify deselected");
    cyc(0, 0, 1, 1, 1, 1, 0, 0, "R9 qualify deselected");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, "R9 pd selected");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule